// File: doc/BRIEF.md
# Compare-Register Counter Waveform Generator

This block drives one waveform pin from a counter that starts at a programmable load value, not at zero. Two compare thresholds set where the count stops or where the output changes. A mode input picks one of four behaviours:

- counting to a selectable limit, with the output toggling each time the limit is reached;
- a one-shot delay that can be retriggered;
- pulse-width modulation, where one threshold sets the low time and the other sets the period;
- up/down counting, where the gate input sets the direction.

The counter moves only on cycles where the count-enable input `tick` is high. The surrounding logic supplies `tick`, either as a prescaled timebase or as a qualified external clock event. The gate input is assumed to be debounced already. Its polarity can be inverted, and in one-shot mode its active-going edge acts as a trigger. Software can also trigger through `sw_trig`. The thresholds and the load value are captured into shadow registers when the counter starts and again at each reload. A write to them part-way through a period therefore takes effect only from the next period.

Top module: `cmpwave_top`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `count` is 0, both match strobes are 0 and `wave_out` equals `out_invert`.
- R2: With `mode` 0 (limit), 2 (PWM) or 3 (direction), a rising `enable` loads `load_val` into `count` at the next edge. After that, `count` changes only on edges where `tick` is high, and in limit mode it moves up by one per tick.
- R3: In limit mode the end value is chosen by `stop_sel`: 0 selects compare 0, 1 selects compare 1, and 2 or 3 select all ones. A tick taken at the end value reloads `load_val` when `reload_en` is 1 and toggles the output level, so the period is end minus load plus one ticks.
- R4: With `reload_en` 0, the tick taken at the end value stops the counter. `count` then holds the end value and no further match strobes occur. In limit and one-shot modes the output keeps its last level.
- R5: With `mode` 1 (one-shot), a start happens while `enable` is high on any edge with `sw_trig` high or with a rising level of `gate_in` XOR `gate_invert`. A start loads `load_val` and drives the output low. The count climbs to compare 0, and the tick taken there toggles the output high. A later trigger restarts the sequence, even when the previous one has finished.
- R6: In PWM mode the count runs from the load value to compare 1 and then reloads. The output is high exactly while `count` is greater than or equal to compare 0, and low otherwise.
- R7: In PWM mode with `gate_ctrl` 1, a gate level (after `gate_invert`) of 0 forces the output inactive and returns `count` to the load value. A gate level of 1 lets generation run.
- R8: In direction mode the count rises by one per tick while the gate level is 1 and falls by one while it is 0, wrapping modulo 2^WIDTH. The output is high while `count` is at or above compare 0.
- R9: `match0` or `match1` is high for one cycle exactly when an update (start, tick or reload) has just made `count` equal to the captured compare 0 or compare 1 value.
- R10: Compare and load values are captured only at a start or a reload. Changing `cmp0_val` or `cmp1_val` mid-period leaves the current period unchanged.
- R11: While `enable` is low, `count` holds its value and the output sits at its inactive level, which is `out_invert`.
- R12: `wave_out` is the internal level XOR `out_invert` in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run enable; its rising edge starts the non-one-shot modes |
| tick | input | 1 | Count enable for this cycle |
| gate_in | input | 1 | Debounced gate / direction input |
| gate_invert | input | 1 | Inverts the gate before use |
| gate_ctrl | input | 1 | In PWM mode, gate level starts and stops generation |
| sw_trig | input | 1 | Software trigger for one-shot mode |
| mode_sel | input | 2 | 0 limit, 1 one-shot, 2 PWM, 3 direction |
| stop_sel | input | 2 | Limit-mode end value: 0 compare 0, 1 compare 1, 2/3 all ones |
| reload_en | input | 1 | Reload at the end value instead of stopping |
| out_invert | input | 1 | Inverts the output level |
| load_val | input | WIDTH | Start / reload value |
| cmp0_val | input | WIDTH | Compare 0 threshold |
| cmp1_val | input | WIDTH | Compare 1 threshold |
| wave_out | output | 1 | Waveform output |
| count | output | WIDTH | Current count |
| match0 | output | 1 | Count reached compare 0 strobe |
| match1 | output | 1 | Count reached compare 1 strobe |

## Verification
The bench builds the block with WIDTH set to 8. This brings the all-ones end value and the wrap from 0 down to 255 within a few cycles. It also allows a full grid of PWM settings: the load value, the compare-0 offset and the compare-1 offset are each swept over several values, and the count and output are checked on every cycle of two full periods. Every expected count, output level and strobe comes from modulo arithmetic on the period length.

// File: rtl/cmpwave_pkg.sv
package cmpwave_pkg;

    typedef enum logic [1:0] {
        MODE_LIMIT   = 2'd0,
        MODE_ONESHOT = 2'd1,
        MODE_PWM     = 2'd2,
        MODE_DIR     = 2'd3
    } wave_mode_e;

    typedef enum logic [1:0] {
        STOP_CMP0  = 2'd0,
        STOP_CMP1  = 2'd1,
        STOP_FULL  = 2'd2,
        STOP_FULL2 = 2'd3
    } stop_sel_e;

    localparam int NUM_CMP = 2;

    // Modes whose output is a level compare against compare 0
    function automatic logic is_level_mode(wave_mode_e m);
        return (m == MODE_PWM) || (m == MODE_DIR);
    endfunction

    // Modes that begin counting on the rising edge of enable
    function automatic logic starts_on_enable(wave_mode_e m);
        return m != MODE_ONESHOT;
    endfunction

endpackage

// File: rtl/cmpwave_trig.sv
module cmpwave_trig
    import cmpwave_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       enable,
    input  logic       gate_in,
    input  logic       gate_invert,
    input  logic       sw_trig,
    input  wave_mode_e mode,
    output logic       gate_lvl,
    output logic       start
);

    logic en_d;
    logic gate_d;
    logic gate_rise;

    assign gate_lvl  = gate_in ^ gate_invert;
    assign gate_rise = gate_lvl && !gate_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_d   <= 1'b0;
            gate_d <= 1'b0;
        end else begin
            en_d   <= enable;
            gate_d <= gate_lvl;
        end
    end

    always_comb begin
        if (!enable)
            start = 1'b0;
        else if (starts_on_enable(mode))
            start = !en_d;
        else
            start = sw_trig || gate_rise;
    end

    // Free-running modes start once per enable rise
    assert_single_start_R2: assert property (@(posedge clk) disable iff (rst)
        (start && starts_on_enable(mode) && $stable(mode)) |=> !start || !starts_on_enable(mode));

endmodule

// File: rtl/cmpwave_core.sv
module cmpwave_core
    import cmpwave_pkg::*;
#(
    parameter int WIDTH = 32
)(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 enable,
    input  logic                 tick,
    input  logic                 start,
    input  logic                 gate_lvl,
    input  logic                 gate_ctrl,
    input  logic                 reload_en,
    input  wave_mode_e           mode,
    input  stop_sel_e            stop_sel,
    input  logic [WIDTH-1:0]     load_val,
    input  logic [WIDTH-1:0]     cmp0_val,
    input  logic [WIDTH-1:0]     cmp1_val,
    output logic [WIDTH-1:0]     cnt,
    output logic [WIDTH-1:0]     cmp0_sh,
    output logic                 running,
    output logic                 out_q,
    output logic                 hold,
    output logic [NUM_CMP-1:0]   match
);

    localparam logic [WIDTH-1:0] FULL = {WIDTH{1'b1}};

    typedef struct packed {
        logic [WIDTH-1:0] ld;
        logic [WIDTH-1:0] c1;
        logic [WIDTH-1:0] c0;
    } thr_t;

    thr_t             thr_q;
    thr_t             thr_d;
    thr_t             fresh;
    logic [WIDTH-1:0] cnt_d;
    logic [WIDTH-1:0] end_val;
    logic             run_d;
    logic             outq_d;
    logic             upd;
    logic [WIDTH-1:0] cmp_next [NUM_CMP];

    assign fresh   = '{ld: load_val, c1: cmp1_val, c0: cmp0_val};
    assign hold    = (mode == MODE_PWM) && gate_ctrl && !gate_lvl;
    assign cmp0_sh = thr_q.c0;

    always_comb begin
        case (mode)
            MODE_PWM:     end_val = thr_q.c1;
            MODE_ONESHOT: end_val = thr_q.c0;
            default: begin
                case (stop_sel)
                    STOP_CMP0: end_val = thr_q.c0;
                    STOP_CMP1: end_val = thr_q.c1;
                    default:   end_val = FULL;
                endcase
            end
        endcase
    end

    always_comb begin
        cnt_d  = cnt;
        thr_d  = thr_q;
        run_d  = running;
        outq_d = out_q;
        upd    = 1'b0;
        if (!enable) begin
            run_d  = 1'b0;
            outq_d = 1'b0;
        end else if (start) begin
            cnt_d  = load_val;
            thr_d  = fresh;
            run_d  = 1'b1;
            outq_d = 1'b0;
            upd    = 1'b1;
        end else if (running && hold) begin
            if (cnt != thr_q.ld) begin
                cnt_d = thr_q.ld;
                upd   = 1'b1;
            end
        end else if (running && tick) begin
            upd = 1'b1;
            if (mode == MODE_DIR) begin
                cnt_d = gate_lvl ? cnt + 1'b1 : cnt - 1'b1;
            end else if (cnt == end_val) begin
                if (mode != MODE_PWM)
                    outq_d = !out_q;
                if (reload_en) begin
                    cnt_d = load_val;
                    thr_d = fresh;
                end else begin
                    run_d = 1'b0;
                    upd   = 1'b0;
                end
            end else begin
                cnt_d = cnt + 1'b1;
            end
        end
    end

    assign cmp_next[0] = thr_d.c0;
    assign cmp_next[1] = thr_d.c1;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            thr_q   <= '0;
            running <= 1'b0;
            out_q   <= 1'b0;
        end else begin
            cnt     <= cnt_d;
            thr_q   <= thr_d;
            running <= run_d;
            out_q   <= outq_d;
        end
    end

    for (genvar i = 0; i < NUM_CMP; i++) begin : g_match
        always_ff @(posedge clk) begin
            if (rst)
                match[i] <= 1'b0;
            else
                match[i] <= upd && (cnt_d == cmp_next[i]);
        end
    end

    assert_match0_equal_R9: assert property (@(posedge clk) disable iff (rst)
        match[0] |-> (cnt == thr_q.c0));

    assert_match1_equal_R9: assert property (@(posedge clk) disable iff (rst)
        match[1] |-> (cnt == thr_q.c1));

    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (!enable && $past(!enable)) |-> $stable(cnt));

    assert_stopped_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (enable && !running && !start) |=> $stable(cnt));

    assert_no_tick_R2: assert property (@(posedge clk) disable iff (rst)
        (enable && running && !tick && !start && !hold) |=> $stable(cnt));

    assert_oneshot_low_R5: assert property (@(posedge clk) disable iff (rst)
        (start && mode == MODE_ONESHOT) |=> !out_q);

endmodule

// File: rtl/cmpwave_wave.sv
module cmpwave_wave
    import cmpwave_pkg::*;
#(
    parameter int WIDTH = 32
)(
    input  logic             clk,
    input  logic             rst,
    input  wave_mode_e       mode,
    input  logic             running,
    input  logic             hold,
    input  logic             out_q,
    input  logic             out_invert,
    input  logic [WIDTH-1:0] cnt,
    input  logic [WIDTH-1:0] cmp0_sh,
    output logic             wave_out
);

    logic level;
    logic raw;

    assign level = running && !hold && (cnt >= cmp0_sh);
    assign raw   = is_level_mode(mode) ? level : out_q;

    assign wave_out = raw ^ out_invert;

    assert_idle_level_R12: assert property (@(posedge clk) disable iff (rst)
        (!running && is_level_mode(mode)) |-> (wave_out == out_invert));

    assert_hold_inactive_R7: assert property (@(posedge clk) disable iff (rst)
        hold |-> (wave_out == out_invert));

endmodule

// File: rtl/cmpwave_top.sv
module cmpwave_top
    import cmpwave_pkg::*;
#(
    parameter int WIDTH = 32
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             tick,
    input  logic             gate_in,
    input  logic             gate_invert,
    input  logic             gate_ctrl,
    input  logic             sw_trig,
    input  logic [1:0]       mode_sel,
    input  logic [1:0]       stop_sel,
    input  logic             reload_en,
    input  logic             out_invert,
    input  logic [WIDTH-1:0] load_val,
    input  logic [WIDTH-1:0] cmp0_val,
    input  logic [WIDTH-1:0] cmp1_val,
    output logic             wave_out,
    output logic [WIDTH-1:0] count,
    output logic             match0,
    output logic             match1
);

    wave_mode_e         mode;
    stop_sel_e          ssel;
    logic               gate_lvl;
    logic               start;
    logic [WIDTH-1:0]   cnt;
    logic [WIDTH-1:0]   cmp0_sh;
    logic               running;
    logic               out_q;
    logic               hold;
    logic [NUM_CMP-1:0] match;

    assign mode = wave_mode_e'(mode_sel);
    assign ssel = stop_sel_e'(stop_sel);

    cmpwave_trig u_trig (
        .clk         (clk),
        .rst         (rst),
        .enable      (enable),
        .gate_in     (gate_in),
        .gate_invert (gate_invert),
        .sw_trig     (sw_trig),
        .mode        (mode),
        .gate_lvl    (gate_lvl),
        .start       (start)
    );

    cmpwave_core #(.WIDTH(WIDTH)) u_core (
        .clk       (clk),
        .rst       (rst),
        .enable    (enable),
        .tick      (tick),
        .start     (start),
        .gate_lvl  (gate_lvl),
        .gate_ctrl (gate_ctrl),
        .reload_en (reload_en),
        .mode      (mode),
        .stop_sel  (ssel),
        .load_val  (load_val),
        .cmp0_val  (cmp0_val),
        .cmp1_val  (cmp1_val),
        .cnt       (cnt),
        .cmp0_sh   (cmp0_sh),
        .running   (running),
        .out_q     (out_q),
        .hold      (hold),
        .match     (match)
    );

    cmpwave_wave #(.WIDTH(WIDTH)) u_wave (
        .clk        (clk),
        .rst        (rst),
        .mode       (mode),
        .running    (running),
        .hold       (hold),
        .out_q      (out_q),
        .out_invert (out_invert),
        .cnt        (cnt),
        .cmp0_sh    (cmp0_sh),
        .wave_out   (wave_out)
    );

    assign count  = cnt;
    assign match0 = match[0];
    assign match1 = match[1];

    assert_reset_clear_R1: assert property (@(posedge clk)
        $past(rst) |-> (count == '0 && !match0 && !match1));

endmodule

// File: tb/tb_cmpwave_top.sv
`timescale 1ns/1ps
module tb_cmpwave_top;

    localparam int W = 8;
    localparam int MAXV = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         enable = 1'b0, tick = 1'b0, gate_in = 1'b0, gate_invert = 1'b0;
    logic         gate_ctrl = 1'b0, sw_trig = 1'b0, reload_en = 1'b0, out_invert = 1'b0;
    logic [1:0]   mode_sel = 2'd0, stop_sel = 2'd0;
    logic [W-1:0] load_val = '0, cmp0_val = '0, cmp1_val = '0;
    logic         wave_out, match0, match1;
    logic [W-1:0] count;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    cmpwave_top #(.WIDTH(W)) dut (
        .clk(clk), .rst(rst), .enable(enable), .tick(tick), .gate_in(gate_in),
        .gate_invert(gate_invert), .gate_ctrl(gate_ctrl), .sw_trig(sw_trig),
        .mode_sel(mode_sel), .stop_sel(stop_sel), .reload_en(reload_en),
        .out_invert(out_invert), .load_val(load_val), .cmp0_val(cmp0_val),
        .cmp1_val(cmp1_val), .wave_out(wave_out), .count(count),
        .match0(match0), .match1(match1)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic stop_run();
        int last;
        last = int'(count);
        enable = 1'b0;
        @(negedge clk);
        check("R11 count holds when disabled", int'(count), last);
        check("R11 output inactive when disabled", int'(wave_out), int'(out_invert));
        @(negedge clk);
    endtask

    // Limit mode with reload
    task automatic run_limit(input int ld, input int c0, input int c1, input int sel,
                             input int n, input bit sparse);
        int endv, per, k, ev;
        endv = (sel == 0) ? c0 : (sel == 1) ? c1 : MAXV;
        per = endv - ld + 1;
        mode_sel = 2'd0; stop_sel = sel[1:0]; reload_en = 1'b1;
        load_val = ld[W-1:0]; cmp0_val = c0[W-1:0]; cmp1_val = c1[W-1:0];
        tick = !sparse; enable = 1'b1;
        k = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ev = ld + (k % per);
            check("R2 R3 limit count", int'(count), ev);
            check("R3 limit output toggle", int'(wave_out), (k / per) % 2);
            if (!sparse) begin
                check("R9 match0", int'(match0), int'(ev == c0));
                check("R9 match1", int'(match1), int'(ev == c1));
            end
            tick = sparse ? (i % 2 == 0) : 1'b1;
            if (tick) k++;
        end
        stop_run();
    endtask

    // PWM with reload; bench-side shadow model
    task automatic run_pwm(input int ld, input int c0, input int c1, input int n,
                           input int chg_at, input int nc0, input int nc1);
        int ev, e0, e1;
        mode_sel = 2'd2; reload_en = 1'b1; tick = 1'b1;
        load_val = ld[W-1:0]; cmp0_val = c0[W-1:0]; cmp1_val = c1[W-1:0];
        enable = 1'b1;
        ev = ld; e0 = c0; e1 = c1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check("R6 R10 pwm count", int'(count), ev);
            check("R6 R12 pwm output", int'(wave_out), int'(ev >= e0) ^ int'(out_invert));
            check("R9 pwm match0", int'(match0), int'(ev == e0));
            check("R9 pwm match1", int'(match1), int'(ev == e1));
            if (i == chg_at) begin
                cmp0_val = nc0[W-1:0]; cmp1_val = nc1[W-1:0];
            end
            if (ev == e1) begin
                ev = ld; e0 = int'(cmp0_val); e1 = int'(cmp1_val);
            end else begin
                ev = ev + 1;
            end
        end
        stop_run();
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog expired actual 0 expected 1");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int ev;
        repeat (3) @(negedge clk);
        check("R1 reset count", int'(count), 0);
        check("R1 reset match0", int'(match0), 0);
        check("R1 reset wave", int'(wave_out), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 count after reset", int'(count), 0);
        check("R1 match1 after reset", int'(match1), 0);

        // R2 R3 limit mode, all end selections, continuous and sparse ticks
        run_limit(3, 5, 7, 1, 20, 1'b0);
        run_limit(2, 6, 9, 0, 20, 1'b0);
        run_limit(250, 251, 252, 2, 20, 1'b0);
        run_limit(248, 0, 0, 3, 20, 1'b0);
        run_limit(4, 6, 8, 1, 24, 1'b1);

        // R4 no reload: stop at end
        mode_sel = 2'd0; stop_sel = 2'd1; reload_en = 1'b0; tick = 1'b1;
        load_val = 8'd1; cmp0_val = 8'd9; cmp1_val = 8'd4;
        enable = 1'b1;
        for (int k = 0; k < 9; k++) begin
            @(negedge clk);
            check("R4 count stops at end", int'(count), (k < 3) ? 1 + k : 4);
            check("R4 output keeps level", int'(wave_out), int'(k >= 4));
            check("R4 R9 no strobe after stop", int'(match1), int'(k == 3));
        end
        stop_run();

        // R5 one-shot: software trigger, retrigger, gate edges of both polarities
        mode_sel = 2'd1; reload_en = 1'b0; tick = 1'b1;
        load_val = 8'd2; cmp0_val = 8'd5; cmp1_val = 8'd0;
        enable = 1'b1; sw_trig = 1'b1;
        for (int k = 0; k < 7; k++) begin
            @(negedge clk);
            sw_trig = 1'b0;
            check("R5 oneshot count", int'(count), (k < 3) ? 2 + k : 5);
            check("R5 oneshot output", int'(wave_out), int'(k >= 4));
        end
        sw_trig = 1'b1;
        @(negedge clk);
        sw_trig = 1'b0;
        check("R5 sw retrigger count", int'(count), 2);
        check("R5 sw retrigger output low", int'(wave_out), 0);
        repeat (6) @(negedge clk);
        check("R5 finished high", int'(wave_out), 1);
        gate_in = 1'b1;
        @(negedge clk);
        check("R5 gate rise retrigger", int'(count), 2);
        check("R5 gate retrigger output", int'(wave_out), 0);
        repeat (6) @(negedge clk);
        gate_invert = 1'b1;
        repeat (2) @(negedge clk);
        check("R5 inverted gate fall ignored", int'(count), 5);
        gate_in = 1'b0;
        @(negedge clk);
        check("R5 inverted gate trigger", int'(count), 2);
        stop_run();
        gate_invert = 1'b0;
        @(negedge clk);

        // R6 R9 PWM grid sweep
        for (int ld = 0; ld <= 3; ld += 3)
            for (int d0 = 0; d0 < 4; d0++)
                for (int d1 = 0; d1 < 4; d1++)
                    run_pwm(ld, ld + d0, ld + d0 + d1,
                            2 * (d0 + d1 + 1) + 1, -1, 0, 0);

        // R10 mid-period compare change takes effect next period
        run_pwm(0, 2, 5, 20, 2, 4, 7);

        // R12 inverted PWM output
        out_invert = 1'b1;
        run_pwm(0, 1, 3, 8, -1, 0, 0);
        out_invert = 1'b0;

        // R7 PWM gate start/stop
        mode_sel = 2'd2; gate_ctrl = 1'b1; gate_in = 1'b0; reload_en = 1'b1; tick = 1'b1;
        load_val = 8'd0; cmp0_val = 8'd2; cmp1_val = 8'd4;
        enable = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R7 gate low holds load", int'(count), 0);
            check("R7 gate low output", int'(wave_out), 0);
        end
        gate_in = 1'b1;
        ev = 1;
        for (int k = 0; k < 7; k++) begin
            @(negedge clk);
            check("R7 gate high runs", int'(count), ev);
            check("R7 gate high output", int'(wave_out), int'(ev >= 2));
            ev = (ev == 4) ? 0 : ev + 1;
        end
        gate_in = 1'b0;
        @(negedge clk);
        check("R7 gate drop returns to load", int'(count), 0);
        check("R7 gate drop output", int'(wave_out), 0);
        stop_run();
        gate_ctrl = 1'b0;

        // R8 direction mode
        mode_sel = 2'd3; load_val = 8'd10; cmp0_val = 8'd12; cmp1_val = 8'd200;
        gate_in = 1'b1; tick = 1'b1; enable = 1'b1;
        ev = 10;
        for (int k = 0; k < 11; k++) begin
            @(negedge clk);
            check("R8 direction count", int'(count), ev);
            check("R8 direction output", int'(wave_out), int'(ev >= 12));
            check("R8 R9 direction match0", int'(match0), int'(ev == 12));
            gate_in = (k < 4);
            ev = (ev + (gate_in ? 1 : -1)) & MAXV;
        end
        stop_run();
        load_val = 8'd1; gate_in = 1'b0; enable = 1'b1;
        ev = 1;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check("R8 downward wrap", int'(count), ev);
            ev = (ev - 1) & MAXV;
        end
        stop_run();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule